// File: doc/BRIEF.md
# Multi-Address I2C Target Controller

This block is an I2C target that runs from the chip's own system clock. It oversamples the open-drain SCL and SDA lines and watches them for start and stop conditions. After a start it shifts in the first byte, most significant bit first, and compares the seven upper bits against a table of up to four programmable 7-bit addresses. When one of them matches, it pulls SDA low on the ninth clock to acknowledge. It then reports which table entry matched and which direction was requested.

After every acknowledge clock the target holds SCL low, which stretches the clock. It keeps SCL low until local logic answers with a one-cycle `local_ready` strobe. In a write transfer every received byte is handed over with a strobe and acknowledged automatically. In a read transfer the target raises a request, and local logic answers by presenting the byte to send together with the ready strobe. The controller's acknowledge after each byte decides whether another byte is requested or whether the target lets go of the bus.

The bus pads are modelled as active-low drive enables. The chip's pad logic turns them into open-drain outputs.

Top module: `i2c_multi_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) restarts address reception from any state, including a repeated start in the middle of a transfer. A stop condition (SDA rising while SCL is high) returns the target to idle with both line drives released. An address byte cut short by a stop produces no strobe.
- R2: The first byte after a start is taken most significant bit first. Its bits 7..1 are the address. Its bit 0 is the direction: 0 means the controller writes to the target, 1 means the target sends data.
- R3: Entry i of `own_addrs` occupies bits 7i+6..7i. When the received address equals an entry, `addr_hit` pulses for one cycle after the eighth rising SCL edge, with `hit_index` = i and `is_read` = the direction bit. When several entries hold the same address, the lowest index is reported.
- R4: When the address matches no entry, the target never drives SDA, which gives a NACK. It raises no strobe and ignores the bus until the next start.
- R5: After a matched address and after every written data byte, the target pulls SDA low from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth. Any change of the target's SDA drive happens only while SCL is low.
- R6: At the SCL fall that ends each acknowledge clock, the target pulls SCL low and holds it until `local_ready` pulses. It releases SCL one cycle after that pulse. `local_ready` has no effect while the target is not holding SCL.
- R7: In a write transfer, `rx_strobe` pulses for one cycle with the received byte on `rx_data` after the eighth rising SCL edge of each data byte. At most one of `addr_hit`, `rx_strobe` and `tx_request` is high in any cycle.
- R8: In a read transfer, `tx_request` pulses in the cycle the clock stretch begins. On `local_ready` the target captures `tx_data` and sends it most significant bit first, changing SDA only after SCL falls.
- R9: In a read transfer, if the controller holds SDA low on the ninth clock (ACK), the target issues another `tx_request`. If SDA is high (NACK), the target keeps SDA released and requests nothing more until the next stop or start.
- R10: While reset is held and right after it, both line drives are released and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| own_addrs | input | 7*NUM_ADDR | Address table; entry i in bits 7i+6..7i |
| local_ready | input | 1 | One-cycle strobe that ends a clock stretch |
| tx_data | input | 8 | Byte to send, captured on `local_ready` during a read stretch |
| rx_data | output | 8 | Last byte received in a write transfer |
| rx_strobe | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| tx_request | output | 1 | One-cycle pulse: a byte to send is needed |
| addr_hit | output | 1 | One-cycle pulse: the address matched |
| hit_index | output | IDX_W | Index of the matching table entry |
| is_read | output | 1 | Direction bit of the matched address byte |

## Verification
Each result of this block is registered three clock edges after the bus edge that causes it: two synchronizer flops, then the state register. An address hit or received byte therefore appears three cycles after the eighth rising SCL edge. An ACK or a clock stretch appears three cycles after the falling SCL edge, and SCL is released one cycle after `local_ready`. The bench holds every SCL phase for 40 cycles, so each line level it samples in mid-phase lies well after those delays. A monitor compares each strobe on the falling clock edge at which it is present, against a queue that the transfer tasks fill before they drive the matching bits. The stretch checks sample the SCL line a fixed 12 cycles into each hold and again one cycle after the ready strobe.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   // sequencer states of the target
   typedef enum logic [2:0] {
      ST_IDLE,    // waiting for a start condition
      ST_ADDR,    // shifting in the address byte
      ST_PREACK,  // eighth bit taken, waiting for SCL fall to drive ACK
      ST_ACK,     // driving ACK through the ninth clock
      ST_HOLD,    // stretching SCL until local side is ready
      ST_WBITS,   // receiving a data byte
      ST_RBITS,   // sending a data byte
      ST_RACK     // sampling controller ACK/NACK after a sent byte
   } tgt_state_e;

   localparam int ADDR_W = 7;
   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_line_watch: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_chain;
   logic [SYNC_STAGES-1:0] sda_chain;
   logic                   scl_q;
   logic                   sda_q;

   // idle bus lines sit high, so every flop resets to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_raw};
         sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_raw};
         scl_q     <= scl_chain[SYNC_STAGES-1];
         sda_q     <= sda_chain[SYNC_STAGES-1];
      end
   end

   assign scl_lvl  = scl_chain[SYNC_STAGES-1];
   assign sda_lvl  = sda_chain[SYNC_STAGES-1];
   assign scl_rise = scl_lvl & ~scl_q;
   assign scl_fall = ~scl_lvl & scl_q;
   // SDA edges that occur with SCL high on both samples are bus conditions
   assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
   parameter int NUM_ADDR = 4,
   parameter int IDX_W    = 2
) (
   input  logic [6:0]            probe,
   input  logic [NUM_ADDR*7-1:0] table_flat,
   output logic                  hit,
   output logic [IDX_W-1:0]      idx
);

   logic [NUM_ADDR-1:0] eq;

   generate
      for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
         assign eq[g] = (table_flat[g*7 +: 7] == probe);
      end
   endgenerate

   // scan from the top so the lowest matching index is the one kept
   always_comb begin
      hit = |eq;
      idx = '0;
      for (int i = NUM_ADDR - 1; i >= 0; i--) begin
         if (eq[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/i2c_multi_target.sv
module i2c_multi_target
   import i2c_tgt_pkg::*;
#(
   parameter int  NUM_ADDR    = 4,
   parameter int  SYNC_STAGES = 2,
   localparam int IDX_W       = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  scl_drive_low,
   output logic                  sda_drive_low,
   input  logic [NUM_ADDR*7-1:0] own_addrs,
   input  logic                  local_ready,
   input  logic [7:0]            tx_data,
   output logic [7:0]            rx_data,
   output logic                  rx_strobe,
   output logic                  tx_request,
   output logic                  addr_hit,
   output logic [IDX_W-1:0]      hit_index,
   output logic                  is_read
);

   generate
      if (NUM_ADDR < 1 || NUM_ADDR > 4) begin : g_bad_cfg
         $error("i2c_multi_target: NUM_ADDR must be 1 to 4");
      end
   endgenerate

   localparam int CNT_W = $clog2(BYTE_W);

   logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
   logic             m_hit;
   logic [IDX_W-1:0] m_idx;
   tgt_state_e       state;
   logic [7:0]       shreg;
   logic [CNT_W-1:0] bit_cnt;
   logic             ctl_ack;

   i2c_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_raw  (scl_in),
      .sda_raw  (sda_in),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   // at the eighth rise shreg[6:0] holds the seven address bits
   i2c_addr_match #(.NUM_ADDR(NUM_ADDR), .IDX_W(IDX_W)) u_match (
      .probe      (shreg[6:0]),
      .table_flat (own_addrs),
      .hit        (m_hit),
      .idx        (m_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         shreg         <= '0;
         bit_cnt       <= '0;
         ctl_ack       <= 1'b0;
         scl_drive_low <= 1'b0;
         sda_drive_low <= 1'b0;
         rx_data       <= '0;
         rx_strobe     <= 1'b0;
         tx_request    <= 1'b0;
         addr_hit      <= 1'b0;
         hit_index     <= '0;
         is_read       <= 1'b0;
      end else begin
         addr_hit   <= 1'b0;
         rx_strobe  <= 1'b0;
         tx_request <= 1'b0;
         if (start_ev) begin
            state         <= ST_ADDR;
            bit_cnt       <= '0;
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
         end else if (stop_ev) begin
            state         <= ST_IDLE;
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[6:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                     if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        if (m_hit) begin
                           state     <= ST_PREACK;
                           addr_hit  <= 1'b1;
                           hit_index <= m_idx;
                           is_read   <= sda_lvl;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                  end
               end
               ST_PREACK: begin
                  if (scl_fall) begin
                     sda_drive_low <= 1'b1;
                     state         <= ST_ACK;
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_drive_low <= 1'b0;
                     scl_drive_low <= 1'b1;
                     tx_request    <= is_read;
                     state         <= ST_HOLD;
                  end
               end
               ST_HOLD: begin
                  if (local_ready) begin
                     scl_drive_low <= 1'b0;
                     bit_cnt       <= '0;
                     if (is_read) begin
                        shreg         <= tx_data;
                        sda_drive_low <= ~tx_data[7];
                        state         <= ST_RBITS;
                     end else begin
                        state <= ST_WBITS;
                     end
                  end
               end
               ST_WBITS: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[6:0], sda_lvl};
                     bit_cnt <= bit_cnt + 1'b1;
                     if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        rx_data   <= {shreg[6:0], sda_lvl};
                        rx_strobe <= 1'b1;
                        state     <= ST_PREACK;
                     end
                  end
               end
               ST_RBITS: begin
                  if (scl_fall) begin
                     if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        sda_drive_low <= 1'b0;
                        ctl_ack       <= 1'b0;
                        state         <= ST_RACK;
                     end else begin
                        shreg         <= {shreg[6:0], 1'b0};
                        sda_drive_low <= ~shreg[6];
                        bit_cnt       <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     ctl_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (ctl_ack) begin
                        scl_drive_low <= 1'b1;
                        tx_request    <= 1'b1;
                        state         <= ST_HOLD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   p_hit_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hit |-> (own_addrs[int'(hit_index)*7 +: 7] == shreg[7:1]));

   p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!sda_drive_low && !scl_drive_low));

   p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((sda_drive_low != $past(sda_drive_low)) && !$past(start_ev) && !$past(stop_ev))
         |-> !$past(scl_lvl));

   p_stretch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_drive_low && !local_ready && !start_ev && !stop_ev) |=> scl_drive_low);

   p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_hit, rx_strobe, tx_request}));

   p_request_while_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_request |-> (scl_drive_low && is_read));

   p_ack_slot_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK) |-> !sda_drive_low);

endmodule

// File: tb/i2c_multi_target_tb.sv
module i2c_multi_target_tb;

   localparam int H   = 40;  // SCL half period in system clocks
   localparam int DLY = 12;  // local side answer delay in a stretch

   localparam logic [1:0] K_HIT = 2'd0, K_RX = 2'd1, K_REQ = 2'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;  // 250 MHz

   logic        m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic        scl_oe, sda_oe, scl_line, sda_line;
   logic [27:0] addrs;
   logic        ready = 1'b0;
   logic [7:0]  tx_byte = 8'h00;
   logic [7:0]  rx_byte;
   logic        rx_valid, tx_req, hit, is_rd;
   logic [1:0]  hidx;

   assign scl_line = ~(m_scl_low | scl_oe);
   assign sda_line = ~(m_sda_low | sda_oe);

   i2c_multi_target u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_in        (scl_line),
      .sda_in        (sda_line),
      .scl_drive_low (scl_oe),
      .sda_drive_low (sda_oe),
      .own_addrs     (addrs),
      .local_ready   (ready),
      .tx_data       (tx_byte),
      .rx_data       (rx_byte),
      .rx_strobe     (rx_valid),
      .tx_request    (tx_req),
      .addr_hit      (hit),
      .hit_index     (hidx),
      .is_read       (is_rd)
   );

   typedef struct packed {
      logic [1:0] kind;
      logic [7:0] val;
   } ev_t;

   int         n_cmp = 0, n_bad = 0;
   bit         done = 1'b0;
   ev_t        exp_q[$];
   logic [7:0] rd_q[$];
   bit         need_byte = 1'b0;
   bit         sda_chg_bad = 1'b0;
   bit         saw_drive = 1'b0;
   logic       prev_sda_oe = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push_ev(input logic [1:0] k, input logic [7:0] v);
      ev_t e;
      e.kind = k;
      e.val  = v;
      exp_q.push_back(e);
   endtask

   // ---------------- monitor / scoreboard ----------------
   task automatic sb_pop(input logic [1:0] k, input logic [7:0] v, input string req);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk(1'b0, req, "unexpected strobe", int'({k, v}), 0);
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == k && e.val == v, req, "strobe kind/value",
             int'({k, v}), int'({e.kind, e.val}));
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (hit)      sb_pop(K_HIT, {5'b0, is_rd, hidx}, "R3");
         if (rx_valid) sb_pop(K_RX, rx_byte, "R7");
         if (tx_req) begin
            sb_pop(K_REQ, 8'h00, "R8");
            need_byte = 1'b1;
         end
         if ((sda_oe != prev_sda_oe) && scl_line) sda_chg_bad = 1'b1;
         if (sda_oe) saw_drive = 1'b1;
         prev_sda_oe = sda_oe;
      end
   end

   // ---------------- local side responder ----------------
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && scl_oe) begin
            repeat (DLY) @(negedge clk);
            chk(scl_line == 1'b0, "R6", "SCL held low during stretch", scl_line, 0);
            if (need_byte) begin
               tx_byte   = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hEE;
               need_byte = 1'b0;
            end
            ready = 1'b1;
            @(negedge clk);
            ready = 1'b0;
            @(negedge clk);
            chk(scl_oe == 1'b0, "R6", "SCL released after ready", scl_oe, 0);
         end
      end
   end

   // ---------------- controller model ----------------
   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scl_up();
      m_scl_low = 1'b0;
      while (!scl_line) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda_low = 1'b0;
      wt(H);
      scl_up();
      wt(H);
      m_sda_low = 1'b1;
      wt(H);
      m_scl_low = 1'b1;
      wt(4);
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1;
      wt(H);
      scl_up();
      wt(H);
      m_sda_low = 1'b0;
      wt(H);
   endtask

   task automatic m_wbit(input bit b);
      m_sda_low = ~b;
      wt(H);
      scl_up();
      wt(H);
      m_scl_low = 1'b1;
      wt(4);
   endtask

   task automatic m_rbit(output bit b);
      m_sda_low = 1'b0;
      wt(H);
      scl_up();
      wt(H / 2);
      b = sda_line;
      wt(H / 2);
      m_scl_low = 1'b1;
      wt(4);
   endtask

   task automatic m_wbyte(input logic [7:0] d, output bit ack);
      bit nak;
      for (int i = 7; i >= 0; i--) m_wbit(d[i]);
      m_rbit(nak);
      ack = ~nak;
   endtask

   task automatic m_rbyte(output logic [7:0] d, input bit give_ack);
      bit b;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         m_rbit(b);
         d = {d[6:0], b};
      end
      m_wbit(~give_ack);
   endtask

   // write transfer: address then n bytes, no stop
   task automatic wr_txn(input logic [6:0] a, input logic [1:0] idx, input int n,
                         input logic [7:0] d0, input logic [7:0] d1);
      bit ack;
      logic [7:0] d;
      m_start();
      push_ev(K_HIT, {5'b0, 1'b0, idx});
      m_wbyte({a, 1'b0}, ack);
      chk(ack, "R2", "ACK of write address", ack, 1);
      for (int k = 0; k < n; k++) begin
         d = (k == 0) ? d0 : d1;
         push_ev(K_RX, d);
         m_wbyte(d, ack);
         chk(ack, "R5", "ACK of written byte", ack, 1);
      end
   endtask

   // read transfer: address then n bytes, last one NACKed, no stop
   task automatic rd_txn(input logic [6:0] a, input logic [1:0] idx, input int n,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      bit ack;
      logic [7:0] got, want;
      m_start();
      push_ev(K_HIT, {5'b0, 1'b1, idx});
      for (int k = 0; k < n; k++) begin
         want = (k == 0) ? b0 : (k == 1) ? b1 : b2;
         rd_q.push_back(want);
         push_ev(K_REQ, 8'h00);
      end
      m_wbyte({a, 1'b1}, ack);
      chk(ack, "R2", "ACK of read address", ack, 1);
      for (int k = 0; k < n; k++) begin
         want = (k == 0) ? b0 : (k == 1) ? b1 : b2;
         m_rbyte(got, k < n - 1);
         chk(got == want, "R8", "byte sent by target", got, want);
      end
      wt(H);
      chk(sda_oe == 1'b0, "R9", "SDA released after NACK", sda_oe, 0);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      bit ack;
      addrs = {7'h7F, 7'h50, 7'h35, 7'h21};
      wt(5);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R10", "drives during reset",
          {scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      wt(5);
      chk({hit, rx_valid, tx_req, scl_oe, sda_oe} == 5'b0, "R10", "outputs after reset",
          {hit, rx_valid, tx_req, scl_oe, sda_oe}, 0);

      // ready outside a stretch is ignored
      ready = 1'b1;
      wt(1);
      ready = 1'b0;
      wt(3);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R6", "ready while idle ignored",
          {scl_oe, sda_oe}, 0);

      // write to entry 1, two bytes
      wr_txn(7'h35, 2'd1, 2, 8'hA5, 8'h3C);
      m_stop();
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released after stop",
          {scl_oe, sda_oe}, 0);

      // address that matches nothing
      saw_drive = 1'b0;
      m_start();
      m_wbyte({7'h22, 1'b0}, ack);
      chk(!ack, "R4", "NACK on unmatched address", ack, 0);
      m_wbyte(8'h55, ack);
      chk(!ack, "R4", "data after miss not acknowledged", ack, 0);
      m_stop();
      chk(!saw_drive, "R4", "SDA never driven on miss", saw_drive, 0);

      // read from entry 3, three bytes, last NACKed
      rd_txn(7'h7F, 2'd3, 3, 8'h96, 8'h01, 8'hF0);
      m_stop();

      // write then repeated start into a read of entry 2
      wr_txn(7'h21, 2'd0, 1, 8'hC3, 8'h00);
      rd_txn(7'h50, 2'd2, 1, 8'h5A, 8'h00, 8'h00);
      m_stop();

      // address cut short by a stop, then a normal transfer
      m_start();
      for (int i = 7; i >= 4; i--) m_wbit(bit'(8'h6A >> i));
      m_stop();
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "released after aborted address",
          {scl_oe, sda_oe}, 0);
      wr_txn(7'h35, 2'd1, 1, 8'h0F, 8'h00);
      m_stop();

      // duplicate entries: entry 2 now equals entry 0, lowest index wins
      addrs[20:14] = 7'h21;
      wt(4);
      wr_txn(7'h21, 2'd0, 1, 8'h81, 8'h00);
      m_stop();
      m_start();
      m_wbyte({7'h50, 1'b0}, ack);
      chk(!ack, "R3", "replaced address no longer answered", ack, 0);
      m_stop();

      wt(50);
      chk(exp_q.size() == 0, "R7", "all expected strobes seen", exp_q.size(), 0);
      chk(!sda_chg_bad, "R5", "SDA drive moved only with SCL low", sda_chg_bad, 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog expired: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule